// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder (Lower-Triangular Solve)

This block turns a stream of information blocks into a systematic codeword for a quasi-cyclic low-density parity-check code. Each block is Z bits wide. One codeword holds KB information blocks followed by NROWS parity blocks, so a codeword has KB + NROWS block columns. The defaults are 22 information blocks and 46 parity blocks, which gives 68 columns, rate 22/68, and 69632 bits when Z is 1024. The parity-check matrix is built from a base matrix. Each nonzero base entry stands for a Z×Z identity rotated by a shift value. A -1 entry stands for an all-zero block. The shift values come from a fixed formula and are built into the hardware as wiring.

Parity is found by back-substitution on the lower-triangular structure of the check matrix. No generator matrix is used. As each information block arrives, every row accumulator XORs in a rotated copy of that block. After the last information block, one solve cycle does three things. It forms the first core parity block from the XOR of the four core-row sums. It derives the other three core parity blocks by substitution. It folds all four core parity blocks into the extension rows. Each extension parity block is then equal to its own row's sum. The only arithmetic in the datapath is fixed circular rotations and XORs.

Both stream sides use valid/ready handshakes. While information blocks are flowing, each one is passed straight to the output, so back-pressure from the output reaches the input in the same cycle. During the solve cycle and the parity phase, the input is held off. A parity block on the output stays put until the output accepts it.

Top module: `qc_ldpc_alt_enc`

## Requirements
- R1: Base entry H(r,c) is a shift s or -1. A shift s maps block x to y, where y[i] = x[(i+s) mod Z]. A -1 entry maps every block to zero. For an information column c < KB, the entries are as follows. In core rows r < 4, the entry is (11r+5c+3) mod Z when (r+c) mod 4 ≠ 3, and -1 otherwise. In rows r ≥ 4, the entry is (13r+7c+1) mod Z when (3r+c) mod 7 < 2, and -1 otherwise. For a parity column c = KB+k, the entries depend on k. When k = 0, the core rows are 1, 0, -1, 1 for rows 0 to 3. When k is 1 to 3, the entry is 0 in rows k-1 and k, and -1 in the other core rows. When k ≤ 3 and r ≥ 4, the entry is (5r+k) mod Z when (r+k) mod 3 = 0, and -1 otherwise. When k ≥ 4, the entry is 0 only in row k.
- R2: In the information phase, in_ready equals out_ready, out_valid equals in_valid, and out_data equals in_data. The KB information blocks leave unchanged and in order.
- R3: The KB-th accepted information block is followed by exactly one cycle with out_valid and in_ready both low. After that, the NROWS parity blocks leave in order: core blocks 0 to 3 first, then extension blocks 4 to NROWS-1.
- R4: Every codeword that is produced gives an all-zero syndrome against every row of the full check matrix.
- R5: Let S_r be the XOR of the rotated information blocks of row r. The first core parity block is P0 = S0 ^ S1 ^ S2 ^ S3.
- R6: The other core parity blocks are found by back-substitution: P1 = S0 ^ rot(P0,1), P2 = S1 ^ P0 ^ P1, and P3 = S3 ^ rot(P0,1).
- R7: Extension parity block r is S_r XORed with the rotated core parity blocks of row r.
- R8: While a parity block is offered and out_ready is low, out_valid stays high and out_data does not change. in_ready stays low from the solve cycle until the last parity block has been accepted.
- R9: After reset, out_valid is low and in_ready follows out_ready. Once the last parity block is accepted, all row sums are cleared, so the next codeword does not depend on the previous one.
- R10: A -1 entry adds nothing. A message with a single set bit changes only the parity blocks that the formula links to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Information block offered |
| in_ready | output | 1 | Encoder accepts the offered block |
| in_data | input | Z | Information block |
| out_valid | output | 1 | Codeword block offered |
| out_ready | input | 1 | Downstream accepts the codeword block |
| out_data | output | Z | Codeword block, information blocks first, then parity blocks |

## Verification
Two things happen in the same cycle as an information block leaves the encoder: it is forwarded to the output, and it is XORed into every connected row sum. Back-pressure must therefore stall both together. The bench stresses this by toggling in_valid and out_ready from a pseudo-random pattern. It then checks that no information block is lost or counted twice, first by comparing each parity block exactly with an arithmetic model and second by recomputing the full syndrome. Separately, the last parity handshake clears the row sums while a new codeword may already be waiting at the input. A zero message sent right after a random one must therefore produce all-zero parity.

// File: rtl/lqc_pkg.sv
package lqc_pkg;

  localparam int CORE_ROWS = 4;

  typedef enum logic [1:0] {ST_INFO, ST_SOLVE, ST_PAR} enc_state_e;

  // Base-matrix entry: rotation amount, or -1 for an all-zero block.
  function automatic int base_shift(input int r, input int c, input int kb, input int z);
    int pc;
    if (c < kb) begin
      if (r < CORE_ROWS) return (((r + c) % 4) != 3) ? ((r * 11 + c * 5 + 3) % z) : -1;
      return (((r * 3 + c) % 7) < 2) ? ((r * 13 + c * 7 + 1) % z) : -1;
    end
    pc = c - kb;
    if (pc < CORE_ROWS) begin
      if (r < CORE_ROWS) begin
        if (pc == 0) return (r == 2) ? -1 : ((r == 1) ? 0 : (1 % z));
        return (r == pc - 1 || r == pc) ? 0 : -1;
      end
      return (((r + pc) % 3) == 0) ? ((r * 5 + pc) % z) : -1;
    end
    return (pc == r) ? 0 : -1;
  endfunction

endpackage

// File: rtl/lqc_rot.sv
module lqc_rot #(
  parameter int Z = 8,
  parameter int S = 0
) (
  input  logic [Z-1:0] din,
  output logic [Z-1:0] dout
);
  localparam int SM = S % Z;

  for (genvar i = 0; i < Z; i++) begin : g_bit
    assign dout[i] = din[(i + SM) % Z];
  end
endmodule

// File: rtl/lqc_core_solve.sv
module lqc_core_solve #(
  parameter int Z = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0][Z-1:0]   row_sum,
  output logic [3:0][Z-1:0]   par
);
  logic [Z-1:0] p0;
  logic [Z-1:0] p0_rot;

  // Double-diagonal core: identity columns cancel in the sum of all core rows.
  assign p0 = row_sum[0] ^ row_sum[1] ^ row_sum[2] ^ row_sum[3];

  lqc_rot #(.Z(Z), .S(1)) u_rot_p0 (.din(p0), .dout(p0_rot));

  assign par[0] = p0;
  assign par[1] = row_sum[0] ^ p0_rot;
  assign par[2] = row_sum[1] ^ p0 ^ par[1];
  assign par[3] = row_sum[3] ^ p0_rot;

  // R6: core row 2 (unused by the substitution) must still be satisfied
  core_row2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sum[2] ^ par[2] ^ par[3]) == '0);
endmodule

// File: rtl/lqc_row_acc.sv
module lqc_row_acc #(
  parameter int Z     = 8,
  parameter int KB    = 22,
  parameter int ROW   = 0,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              info_en,
  input  logic [CNT_W-1:0]  col,
  input  logic [Z-1:0]      din,
  input  logic              fold_en,
  input  logic [3:0][Z-1:0] par,
  output logic [Z-1:0]      acc
);
  import lqc_pkg::*;

  logic [Z-1:0] info_term [KB];
  logic [Z-1:0] sel_term;
  logic [Z-1:0] fold_term;

  for (genvar c = 0; c < KB; c++) begin : g_info
    localparam int SH = base_shift(ROW, c, KB, Z);
    if (SH >= 0) begin : g_on
      lqc_rot #(.Z(Z), .S(SH)) u_rot (.din(din), .dout(info_term[c]));
    end else begin : g_off
      assign info_term[c] = '0;
    end
  end

  always_comb begin
    sel_term = '0;
    for (int c = 0; c < KB; c++) begin
      if (col == CNT_W'(c)) sel_term = info_term[c];
    end
  end

  if (ROW < CORE_ROWS) begin : g_core
    // Core rows take over their solved parity block.
    assign fold_term = par[ROW];
  end else begin : g_ext
    logic [Z-1:0] pt [CORE_ROWS];
    for (genvar j = 0; j < CORE_ROWS; j++) begin : g_pc
      localparam int SP = base_shift(ROW, KB + j, KB, Z);
      if (SP >= 0) begin : g_on
        lqc_rot #(.Z(Z), .S(SP)) u_rot (.din(par[j]), .dout(pt[j]));
      end else begin : g_off
        assign pt[j] = '0;
      end
    end
    assign fold_term = acc ^ pt[0] ^ pt[1] ^ pt[2] ^ pt[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (clr)     acc <= '0;
    else if (fold_en) acc <= fold_term;
    else if (info_en) acc <= acc ^ sel_term;
  end

  // R9
  row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
endmodule

// File: rtl/qc_ldpc_alt_enc.sv
module qc_ldpc_alt_enc #(
  parameter int Z     = 8,
  parameter int KB    = 22,
  parameter int NROWS = 46
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [Z-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [Z-1:0] out_data
);
  import lqc_pkg::*;

  localparam int NMAX  = (KB > NROWS) ? KB : NROWS;
  localparam int CNT_W = $clog2(NMAX);

  enc_state_e              state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [NROWS-1:0][Z-1:0] acc;
  logic [3:0][Z-1:0]       core_par;
  logic [Z-1:0]            par_blk;
  logic                    in_fire, out_fire;
  logic                    info_en, fold_en, clr;

  always_comb begin
    par_blk = '0;
    for (int r = 0; r < NROWS; r++) begin
      if (cnt_q == CNT_W'(r)) par_blk = acc[r];
    end
  end

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    case (state_q)
      ST_INFO: begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
      end
      ST_PAR: begin
        out_valid = 1'b1;
        out_data  = par_blk;
      end
      default: ;
    endcase
  end

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign info_en  = (state_q == ST_INFO) && in_fire;
  assign fold_en  = (state_q == ST_SOLVE);
  assign clr      = (state_q == ST_PAR) && out_fire && (cnt_q == CNT_W'(NROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INFO;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_INFO: if (in_fire) begin
          if (cnt_q == CNT_W'(KB - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_SOLVE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SOLVE: state_q <= ST_PAR;
        ST_PAR: if (out_fire) begin
          if (cnt_q == CNT_W'(NROWS - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_INFO;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_INFO;
      endcase
    end
  end

  lqc_core_solve #(.Z(Z)) u_solve (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_sum (acc[3:0]),
    .par     (core_par)
  );

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    lqc_row_acc #(.Z(Z), .KB(KB), .ROW(r), .CNT_W(CNT_W)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .info_en (info_en),
      .col     (cnt_q),
      .din     (in_data),
      .fold_en (fold_en),
      .par     (core_par),
      .acc     (acc[r])
    );
  end

  // R8
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAR && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  solve_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INFO && in_fire && cnt_q == CNT_W'(KB - 1)) |=> (!out_valid && !in_ready));

  // R3
  par_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAR) |-> (int'(cnt_q) < NROWS));
endmodule

// File: tb/qc_ldpc_alt_enc_tb.sv
module qc_ldpc_alt_enc_tb;
  localparam int  Z = 8;
  localparam int  KB = 22;
  localparam int  NR = 46;
  localparam int  NB = KB + NR;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [Z-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [Z-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [Z-1:0] msg [KB];
  logic [Z-1:0] cw [NB];
  logic [Z-1:0] ref_par [NR];

  always #(CLK_PERIOD / 2) clk = ~clk;

  qc_ldpc_alt_enc #(.Z(Z), .KB(KB), .NROWS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Base matrix as written in R1
  function automatic int sh(input int r, input int c);
    int k;
    if (c < KB) begin
      if (r < 4) return (((r + c) % 4) != 3) ? ((11 * r + 5 * c + 3) % Z) : -1;
      return (((3 * r + c) % 7) < 2) ? ((13 * r + 7 * c + 1) % Z) : -1;
    end
    k = c - KB;
    if (k == 0 && r < 4) return (r == 2) ? -1 : ((r == 1) ? 0 : 1);
    if (k <= 3 && r < 4) return (r == k - 1 || r == k) ? 0 : -1;
    if (k <= 3) return (((r + k) % 3) == 0) ? ((5 * r + k) % Z) : -1;
    return (k == r) ? 0 : -1;
  endfunction

  function automatic logic [Z-1:0] brot(input logic [Z-1:0] x, input int s);
    logic [Z-1:0] y;
    y = '0;
    if (s >= 0) for (int i = 0; i < Z; i++) y[i] = x[(i + s) % Z];
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [Z-1:0] act, input logic [Z-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic compute_ref();
    logic [Z-1:0] s [NR];
    logic [Z-1:0] p0r;
    for (int r = 0; r < NR; r++) begin
      s[r] = '0;
      for (int c = 0; c < KB; c++) s[r] ^= brot(msg[c], sh(r, c));
    end
    ref_par[0] = s[0] ^ s[1] ^ s[2] ^ s[3];
    p0r = brot(ref_par[0], 1);
    ref_par[1] = s[0] ^ p0r;
    ref_par[2] = s[1] ^ ref_par[0] ^ ref_par[1];
    ref_par[3] = s[3] ^ p0r;
    for (int r = 4; r < NR; r++) begin
      ref_par[r] = s[r];
      for (int j = 0; j < 4; j++) ref_par[r] ^= brot(ref_par[j], sh(r, KB + j));
    end
  endtask

  task automatic run_cw(input int mode, input bit impulse);
    int sent = 0;
    int got = 0;
    int iter = 0;
    bit bubble = 1'b0;
    bit held = 1'b0;
    logic [Z-1:0] held_d = '0;
    logic [Z-1:0] syn;
    while (got < NB) begin
      @(negedge clk);
      step_lfsr();
      in_valid  = (sent < KB) && (mode == 0 || lfsr[0] || lfsr[3]);
      in_data   = (sent < KB) ? msg[sent] : '0;
      out_ready = (mode == 0) || lfsr[1] || lfsr[2];
      #1;
      if (got < KB) begin
        chk(out_valid == in_valid && in_ready == out_ready, "R2 handshake mirror",
            {6'b0, out_valid, in_ready}, {6'b0, in_valid, out_ready});
        if (in_valid) chk(out_data == in_data, "R2 pass-through data", out_data, in_data);
      end else begin
        chk(!in_ready, "R8 input held off", {7'b0, in_ready}, '0);
      end
      if (bubble) begin
        chk(!out_valid && !in_ready, "R3 solve cycle idle", {6'b0, out_valid, in_ready}, '0);
        bubble = 1'b0;
      end
      if (held) chk(out_valid && out_data == held_d, "R8 parity hold", out_data, held_d);
      held = 1'b0;
      if (out_valid && out_ready) begin
        cw[got] = out_data;
        got++;
        if (got == KB) bubble = 1'b1;
      end else if (got >= KB && out_valid) begin
        held = 1'b1;
        held_d = out_data;
      end
      if (in_valid && in_ready) sent++;
      iter++;
      if (iter > 2000) begin
        chk(1'b0, "watchdog R3 codeword incomplete", Z'(got), Z'(NB));
        break;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    compute_ref();
    for (int c = 0; c < KB; c++) chk(cw[c] === msg[c], "R2 information block", cw[c], msg[c]);
    chk(cw[KB] === ref_par[0], "R5 first core parity", cw[KB], ref_par[0]);
    for (int k = 1; k < 4; k++) chk(cw[KB + k] === ref_par[k], "R6 core back-substitution", cw[KB + k], ref_par[k]);
    for (int r = 4; r < NR; r++)
      chk(cw[KB + r] === ref_par[r], impulse ? "R10 impulse extension parity" : "R7 extension parity",
          cw[KB + r], ref_par[r]);
    for (int r = 0; r < NR; r++) begin
      syn = '0;
      for (int c = 0; c < NB; c++) syn ^= brot(cw[c], sh(r, c));
      chk(syn == '0, "R4 syndrome (R1 matrix)", syn, '0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R9 reset state", {6'b0, out_valid, in_ready}, 8'b01);

    for (int c = 0; c < KB; c++) msg[c] = '0;
    run_cw(0, 1'b0);
    for (int c = 0; c < KB; c++) msg[c] = '1;
    run_cw(1, 1'b0);
    for (int i = 0; i < KB; i++) begin
      for (int c = 0; c < KB; c++) msg[c] = '0;
      msg[i] = Z'(1) << (i % Z);
      run_cw(i % 2, 1'b1);
    end
    for (int n = 0; n < 6; n++) begin
      for (int c = 0; c < KB; c++) begin
        step_lfsr();
        msg[c] = lfsr[Z-1:0] ^ Z'(c * 37);
      end
      run_cw(1, 1'b0);
    end
    // R9: zero message right after a random one must give all-zero parity
    for (int c = 0; c < KB; c++) msg[c] = '0;
    run_cw(1, 1'b0);
    for (int r = 0; r < NR; r++) chk(cw[KB + r] == '0, "R9 cleared between codewords", cw[KB + r], '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "watchdog R3 run timeout", '0, '1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule